// File: doc/BRIEF.md
# Write Strobe Qualifier with Power-On Lockout

This block sits between the sampled control pins of a byte-wide non-volatile memory and its page write sequencer. It watches the active-low chip-enable, output-enable and write-enable lines on an oversampling clock. It turns each valid write strobe into exactly one single-cycle write event that carries a captured address and a captured data byte. A write strobe is the window in which chip-enable and write-enable are both low while output-enable is high. Either strobe may fall first, and either may rise first. The address is taken when the later of the two strobes falls, and the data is taken when the first of them rises.

Short low pulses on either strobe are treated as noise and do not open a write. Their minimum accepted width is a parameter counted in sample clocks. The block also enforces hardware protection. While the supply-good input is low, every write is blocked. After supply-good rises, writes stay blocked for a programmable number of sample clocks. A drop of supply-good restarts that wait from zero.

Top module: `wr_strobe_qual`

## Requirements
- R1: A write event is produced whether chip-enable falls before write-enable or write-enable falls before chip-enable, provided both are low together with output-enable high and writes are allowed.
- R2: The captured address is the address sampled at the (GLITCH_CYC+1)-th clock edge counted from the first edge that samples the later strobe low. Address changes after that edge do not alter the captured address.
- R3: The captured data is the data sampled at the first clock edge that samples either strobe high after the write has started. Data values present earlier in the strobe window are not used.
- R4: If output-enable is sampled low at any edge between the start of a write and its end, the write is cancelled and no event is produced.
- R5: A later strobe that is low for fewer than GLITCH_CYC consecutive samples produces no event. A later strobe that is low for exactly GLITCH_CYC samples does produce one.
- R6: While supply-good is low, no write event is produced.
- R7: After supply-good rises, a write can start only once supply-good has been sampled high on PON_CYC consecutive edges. Strobes inside that window produce no event.
- R8: Each accepted strobe window yields one event. The write pulse is high for exactly one cycle, in the cycle after the edge that samples the first strobe rise. The captured data then holds until the next event.
- R9: A single-cycle drop of supply-good restarts the lockout count from zero, even when the lockout had already expired.
- R10: Strobes that are already low when the lockout expires do not start a write. A fresh falling edge is needed.
- R11: Under reset, the write pulse, captured address and captured data are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Sampled chip-enable, active low |
| oe_n_i | input | 1 | Sampled output-enable, active low |
| we_n_i | input | 1 | Sampled write-enable, active low |
| addr_i | input | ADDR_W | Sampled address bus |
| data_i | input | DATA_W | Sampled data bus |
| pwr_good_i | input | 1 | Supply-good indication, high when the supply is valid |
| wr_pulse_o | output | 1 | Single-cycle qualified write event |
| wr_addr_o | output | ADDR_W | Address captured for the current event |
| wr_data_o | output | DATA_W | Data captured for the current event |

## Verification
The event pulse and its data are due one cycle after the edge that first samples a rising strobe. The bench therefore drives every rise on a falling clock edge and reads the outputs on the next falling edge, then reads again one cycle later to confirm that the pulse has dropped and the data has held. The address is captured GLITCH_CYC+1 edges after the later strobe falls. Each vector changes the address and data bus right after that edge, so a capture taken at the wrong edge shows up as a mismatch. Lockout cases allow generous margins of at least a quarter of PON_CYC either side of the boundary, so that they test the count and not a single-cycle race.

// File: rtl/wsq_pkg.sv
`timescale 1ns/1ps
package wsq_pkg;
   // strobe lane indices used by the filter generate loop
   localparam int STB_CE  = 0;
   localparam int STB_WE  = 1;
   localparam int NUM_STB = 2;

   typedef enum logic {
      EV_IDLE  = 1'b0,
      EV_ARMED = 1'b1
   } ev_state_e;
endpackage

// File: rtl/wsq_strobe_filter.sv
`timescale 1ns/1ps
// Qualifies one active-low strobe: low_q_o rises only after the raw line
// has been sampled low on GLITCH_CYC consecutive edges, and drops on the
// edge that samples it high again.
module wsq_strobe_filter #(
   parameter int GLITCH_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n_i,
   output logic low_q_o
);
   generate
      if (GLITCH_CYC < 0) begin : g_bad_cfg
         $error("wsq_strobe_filter: GLITCH_CYC must not be negative");
      end

      if (GLITCH_CYC == 0) begin : g_bypass
         assign low_q_o = ~strobe_n_i;
      end else begin : g_count
         localparam int CW = $clog2(GLITCH_CYC + 1);
         localparam logic [CW-1:0] CNT_MAX = CW'(GLITCH_CYC);

         logic [CW-1:0] low_cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_cnt_q <= '0;
            end else if (strobe_n_i) begin
               low_cnt_q <= '0;
            end else if (low_cnt_q != CNT_MAX) begin
               low_cnt_q <= low_cnt_q + 1'b1;
            end
         end

         assign low_q_o = (low_cnt_q == CNT_MAX);
      end
   endgenerate
endmodule

// File: rtl/wsq_pwr_lockout.sv
`timescale 1ns/1ps
// Holds writes off until supply-good has been seen high for PON_CYC
// consecutive edges; any low sample restarts the count.
module wsq_pwr_lockout #(
   parameter int PON_CYC = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good_i,
   output logic wr_ok_o
);
   generate
      if (PON_CYC < 0) begin : g_bad_cfg
         $error("wsq_pwr_lockout: PON_CYC must not be negative");
      end

      if (PON_CYC == 0) begin : g_bypass
         assign wr_ok_o = pwr_good_i;
      end else begin : g_count
         localparam int CW = $clog2(PON_CYC + 1);
         localparam logic [CW-1:0] CNT_MAX = CW'(PON_CYC);

         logic [CW-1:0] on_cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               on_cnt_q <= '0;
            end else if (!pwr_good_i) begin
               on_cnt_q <= '0;
            end else if (on_cnt_q != CNT_MAX) begin
               on_cnt_q <= on_cnt_q + 1'b1;
            end
         end

         assign wr_ok_o = (on_cnt_q == CNT_MAX);
      end
   endgenerate
endmodule

// File: rtl/wsq_event.sv
`timescale 1ns/1ps
// Forms the write event: opens on the rise of "both strobes qualified low",
// captures the address there, closes on the first raw strobe rise where
// the data is captured, and cancels on output-enable low or lost power.
module wsq_event
   import wsq_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_low_q_i,
   input  logic              we_low_q_i,
   input  logic              ce_n_raw_i,
   input  logic              we_n_raw_i,
   input  logic              oe_n_i,
   input  logic              wr_ok_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              wr_pulse_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);
   ev_state_e         state_q;
   logic              both_low_prev_q;
   logic              pulse_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   logic both_low;
   logic start;
   logic live;
   logic end_seen;
   logic cancel;

   always_comb begin
      both_low = ce_low_q_i & we_low_q_i;
      start    = both_low & ~both_low_prev_q & oe_n_i & wr_ok_i;
      live     = (state_q == EV_ARMED) | start;
      end_seen = ce_n_raw_i | we_n_raw_i;
      cancel   = ~oe_n_i | ~wr_ok_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q         <= EV_IDLE;
         both_low_prev_q <= 1'b0;
         pulse_q         <= 1'b0;
         addr_q          <= '0;
         data_q          <= '0;
      end else begin
         pulse_q         <= 1'b0;
         both_low_prev_q <= both_low;
         if (start) begin
            addr_q <= addr_i;
         end
         if (live) begin
            if (cancel) begin
               state_q <= EV_IDLE;
            end else if (end_seen) begin
               data_q  <= data_i;
               pulse_q <= 1'b1;
               state_q <= EV_IDLE;
            end else begin
               state_q <= EV_ARMED;
            end
         end
      end
   end

   assign wr_pulse_o = pulse_q;
   assign wr_addr_o  = addr_q;
   assign wr_data_o  = data_q;
endmodule

// File: rtl/wr_strobe_qual.sv
`timescale 1ns/1ps
module wr_strobe_qual
   import wsq_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int GLITCH_CYC = 3,
   parameter int PON_CYC    = 1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              we_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pwr_good_i,
   output logic              wr_pulse_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("wr_strobe_qual: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic [NUM_STB-1:0] stb_n_raw;
   logic [NUM_STB-1:0] stb_low_q;
   logic               wr_ok;

   assign stb_n_raw[STB_CE] = ce_n_i;
   assign stb_n_raw[STB_WE] = we_n_i;

   generate
      for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
         wsq_strobe_filter #(
            .GLITCH_CYC (GLITCH_CYC)
         ) u_filt (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_n_i (stb_n_raw[s]),
            .low_q_o    (stb_low_q[s])
         );
      end
   endgenerate

   wsq_pwr_lockout #(
      .PON_CYC (PON_CYC)
   ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_good_i (pwr_good_i),
      .wr_ok_o    (wr_ok)
   );

   wsq_event #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_low_q_i (stb_low_q[STB_CE]),
      .we_low_q_i (stb_low_q[STB_WE]),
      .ce_n_raw_i (stb_n_raw[STB_CE]),
      .we_n_raw_i (stb_n_raw[STB_WE]),
      .oe_n_i     (oe_n_i),
      .wr_ok_i    (wr_ok),
      .addr_i     (addr_i),
      .data_i     (data_i),
      .wr_pulse_o (wr_pulse_o),
      .wr_addr_o  (wr_addr_o),
      .wr_data_o  (wr_data_o)
   );
endmodule

// File: rtl/wsq_checker.sv
`timescale 1ns/1ps
module wsq_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n_i,
   input logic              oe_n_i,
   input logic              we_n_i,
   input logic [DATA_W-1:0] data_i,
   input logic              pwr_good_i,
   input logic              wr_pulse_o,
   input logic [DATA_W-1:0] wr_data_o
);
   // R8: event pulse never lasts longer than one cycle
   p_one_cycle_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse_o |=> !wr_pulse_o);

   // R8: captured data only moves with an event
   p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pulse_o |-> $stable(wr_data_o));

   // R4: output-enable low at an edge forbids an event from that edge
   p_oe_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_i |=> !wr_pulse_o);

   // R6: supply-good low blocks events after the lockout register settles
   p_supply_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good_i |=> ##1 !wr_pulse_o);

   // R3: an event follows an edge that saw a strobe high
   p_end_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse_o |-> $past(ce_n_i || we_n_i));

   // R3: event data equals the bus value at the closing edge
   p_data_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse_o |-> (wr_data_o == $past(data_i)));
endmodule

bind wr_strobe_qual wsq_checker #(
   .DATA_W (DATA_W)
) u_wsq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n_i     (ce_n_i),
   .oe_n_i     (oe_n_i),
   .we_n_i     (we_n_i),
   .data_i     (data_i),
   .pwr_good_i (pwr_good_i),
   .wr_pulse_o (wr_pulse_o),
   .wr_data_o  (wr_data_o)
);

// File: tb/tb_wr_strobe_qual.sv
`timescale 1ns/1ps
module tb_wr_strobe_qual;
   localparam int G   = 3;
   localparam int PON = 40;

   typedef struct packed {
      logic        ce_first;      // 1: chip-enable falls first (write-enable later)
      logic        ce_rise_first; // 1: chip-enable rises first
      logic [3:0]  width;         // low samples of the later strobe
      logic        oe_drop;       // pull output-enable low mid-window
      logic        exp;           // event expected
      logic [12:0] a;
      logic [7:0]  d;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b1, 1'b0, 4'd6, 1'b0, 1'b1, 13'h0123, 8'hA5, 4'd1},  // R1 write-enable controlled
      '{1'b0, 1'b1, 4'd6, 1'b0, 1'b1, 13'h1F40, 8'h3C, 4'd1},  // R1 chip-enable controlled
      '{1'b1, 1'b1, 4'd7, 1'b0, 1'b1, 13'h0AAA, 8'h55, 4'd3},  // R3 data on chip-enable rise
      '{1'b0, 1'b0, 4'd8, 1'b0, 1'b1, 13'h1555, 8'hC3, 4'd2},  // R2 address at later fall
      '{1'b1, 1'b0, 4'd3, 1'b0, 1'b1, 13'h0040, 8'h81, 4'd5},  // R5 exactly threshold
      '{1'b1, 1'b0, 4'd2, 1'b0, 1'b0, 13'h0041, 8'h82, 4'd5},  // R5 glitch
      '{1'b0, 1'b1, 4'd1, 1'b0, 1'b0, 13'h0042, 8'h83, 4'd5},  // R5 glitch on chip-enable
      '{1'b1, 1'b0, 4'd6, 1'b1, 1'b0, 13'h0200, 8'h99, 4'd4}   // R4 output-enable cancel
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr_good = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  data = '0;
   logic        pulse;
   logic [12:0] waddr;
   logic [7:0]  wdata;
   int          n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   wr_strobe_qual #(
      .ADDR_W(13), .DATA_W(8), .GLITCH_CYC(G), .PON_CYC(PON)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
      .addr_i(addr), .data_i(data), .pwr_good_i(pwr_good),
      .wr_pulse_o(pulse), .wr_addr_o(waddr), .wr_data_o(wdata)
   );

   function automatic string req_name(input logic [3:0] r);
      case (r)
         4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
         4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
         4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
         4'd10: return "R10"; default: return "R11";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      string r = req_name(v.req);
      @(negedge clk);
      addr = v.a ^ 13'h1ABC;
      data = 8'h00;
      if (v.ce_first) ce_n = 1'b0; else we_n = 1'b0;
      repeat (2) @(negedge clk);
      addr = v.a;
      if (v.ce_first) we_n = 1'b0; else ce_n = 1'b0;
      for (int i = 1; i <= int'(v.width); i++) begin
         @(negedge clk);
         if (i == G + 1) begin
            addr = ~v.a;
            data = ~v.d;
            if (v.oe_drop) oe_n = 1'b0;
         end
      end
      data = v.d;
      if (v.ce_rise_first) ce_n = 1'b1; else we_n = 1'b1;
      @(negedge clk);
      check(pulse == v.exp, r, "event pulse", pulse, v.exp);
      if (v.exp) begin
         check(waddr == v.a, r, "captured address", waddr, v.a);
         check(wdata == v.d, r, "captured data", wdata, v.d);
      end
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; data = 8'h5A;
      @(negedge clk);
      check(pulse == 1'b0, "R8", "pulse one cycle", pulse, 0);
      if (v.exp) check(wdata == v.d, "R8", "data held", wdata, v.d);
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      vec_t v;
      int   seen;
      // R11: reset state
      repeat (3) @(negedge clk);
      check(pulse == 1'b0, "R11", "reset pulse", pulse, 0);
      check(waddr == '0, "R11", "reset address", waddr, 0);
      check(wdata == '0, "R11", "reset data", wdata, 0);
      rst_n = 1'b1;

      // R6: supply low blocks everything
      v = VECS[0]; v.exp = 1'b0; v.req = 4'd6;
      run_vec(v);

      // R7: inside the lockout window, then after it
      pwr_good = 1'b1;
      v = VECS[1]; v.exp = 1'b0; v.req = 4'd7;
      run_vec(v);
      repeat (PON + 5) @(negedge clk);
      v = VECS[1]; v.req = 4'd7;
      run_vec(v);

      // vector table
      foreach (VECS[k]) run_vec(VECS[k]);

      // R9: one-cycle drop restarts the lockout
      @(negedge clk); pwr_good = 1'b0;
      @(negedge clk); pwr_good = 1'b1;
      v = VECS[3]; v.exp = 1'b0; v.req = 4'd9;
      run_vec(v);
      repeat (PON + 5) @(negedge clk);
      v = VECS[3]; v.req = 4'd9;
      run_vec(v);

      // R10: strobes held low across the end of the lockout
      @(negedge clk); pwr_good = 1'b0;
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk); pwr_good = 1'b1;
      seen = 0;
      for (int i = 0; i < PON + 10; i++) begin
         @(negedge clk);
         if (pulse) seen++;
      end
      data = 8'h11; we_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (pulse) seen++;
      end
      check(seen == 0, "R10", "events from stale strobes", seen, 0);
      ce_n = 1'b1;
      repeat (2) @(negedge clk);
      v = VECS[2]; v.req = 4'd10;
      run_vec(v);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule